// File: doc/BRIEF.md
# Tape Frame Counter

This block keeps the frame tally for one data operation of a magnetic tape controller. Software loads it through a register write port, a data path pulses a frame strobe once per frame moved, and an operation-class input tells the block whether the operation about to start is a write, a read or a write-check. The counter value is visible on an output at all times.

Its meaning depends on the operation. For a write, software first loads the negated frame total (two's complement). Each frame adds one, and the frame that carries the count from all ones to zero ends the write and raises a one-cycle done pulse. For a read or a write-check, the start clears the counter by itself, the frames count upward from zero, and the operation ends on a record-end input. The counter then holds the number of frames transferred. A read may wrap past all ones without ending.

Top module: `tfc_frame_counter`

## Requirements
- R1: While `rst` is high at a clock edge, `frame_cnt` becomes 0 and `op_busy` and `wr_done` become 0, even in the middle of an operation.
- R2: With `op_busy` low, `reg_wr_en` loads `reg_wr_data` into `frame_cnt` at the next edge. Frame strobes while idle leave the count unchanged.
- R3: A start with `op_sel` = 2'b01 (write) keeps the loaded count and raises `op_busy`. Each `frame_stb` while busy adds exactly one to `frame_cnt`.
- R4: During a write, the frame strobe that moves `frame_cnt` from all ones to zero drops `op_busy` and raises `wr_done` at the same edge. `wr_done` stays high for exactly one cycle, and `frame_cnt` reads 0 while it is high.
- R5: A start with `op_sel` = 2'b10 (read) or 2'b11 (write-check) clears `frame_cnt` to 0 whatever was loaded before. After the operation ends, the count equals the number of frames strobed.
- R6: During a read or write-check, wrap-around from all ones to zero is allowed, `op_busy` stays high and `wr_done` never rises.
- R7: `rec_end` while busy ends any operation at the next edge. A frame strobe in the same cycle is still counted.
- R8: While busy, `reg_wr_en` and `op_go` are ignored. The count, the busy flag and the operation class are unchanged by them.
- R9: `op_go` with `op_sel` = 2'b00 starts nothing. `op_busy` stays low and the count is unchanged.
- R10: When idle, `reg_wr_en` together with `op_go` loads the written value and starts a write that uses it. For a read or write-check start in the same cycle, the clear takes priority over the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Software write strobe for the count |
| reg_wr_data | input | CNT_W | Value to load |
| op_go | input | 1 | Start an operation of class `op_sel` |
| op_sel | input | 2 | 00 none, 01 write, 10 read, 11 write-check |
| frame_stb | input | 1 | One frame moved this cycle |
| rec_end | input | 1 | Record end; ends the active operation |
| frame_cnt | output | CNT_W | Current count |
| op_busy | output | 1 | An operation is active |
| wr_done | output | 1 | One-cycle pulse: write reached terminal count |

## Verification
Two functions can land on the same edge: the final frame strobe together with the record end, and a software load together with an operation start. The bench provokes both. It strobes the last frame of a read in the same cycle as `rec_end`, and it raises `reg_wr_en` and `op_go` together for a write and for a read. It judges the outcome against counts computed from the number of strobes: the last frame must be counted, the write must use the loaded value, and the read must start from zero. Writes are swept over every frame total from 1 to 24 and a larger one. A read that runs 65537 frames checks that wrapping raises no done pulse.

// File: rtl/tfc_pkg.sv
package tfc_pkg;

    typedef enum logic [1:0] {
        OPC_NONE  = 2'b00,
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10,
        OPC_WCHK  = 2'b11
    } opc_e;

    typedef struct packed {
        logic busy;
        opc_e kind;
    } op_state_t;

    typedef struct packed {
        logic load;
        logic clear;
        logic step;
    } cnt_cmd_t;

    function automatic logic starts_from_zero(input opc_e k);
        return (k == OPC_READ) || (k == OPC_WCHK);
    endfunction

    function automatic logic is_start(input logic busy, input logic go, input opc_e k);
        return !busy && go && (k != OPC_NONE);
    endfunction

endpackage

// File: rtl/tfc_op_ctrl.sv
module tfc_op_ctrl
    import tfc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      op_go,
    input  logic [1:0] op_sel,
    input  logic      reg_wr_en,
    input  logic      frame_stb,
    input  logic      rec_end,
    input  logic      at_max,
    output cnt_cmd_t  cmd,
    output op_state_t state,
    output logic      done
);

    op_state_t state_q, state_d;
    logic      done_q;
    logic      start;
    logic      wr_term;
    opc_e      req_kind;

    assign req_kind = opc_e'(op_sel);
    assign start    = is_start(state_q.busy, op_go, req_kind);
    assign wr_term  = state_q.busy && (state_q.kind == OPC_WRITE) && frame_stb && at_max;

    always_comb begin
        cmd.clear = start && starts_from_zero(req_kind);
        cmd.load  = !state_q.busy && reg_wr_en && !cmd.clear;
        cmd.step  = state_q.busy && frame_stb;
    end

    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d.busy = 1'b1;
            state_d.kind = req_kind;
        end else if (state_q.busy && (rec_end || wr_term)) begin
            state_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '{busy: 1'b0, kind: OPC_NONE};
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= wr_term;
        end
    end

    assign state = state_q;
    assign done  = done_q;

    p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    p_done_idle_r4: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !state_q.busy);

    p_no_done_read_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q.busy && state_q.kind != OPC_WRITE) |=> !done_q);

    p_busy_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q.busy && !rec_end && !(frame_stb && at_max)) |=> (state_q.busy && $stable(state_q.kind)));

    p_none_no_start_r9: assert property (@(posedge clk) disable iff (rst)
        (!state_q.busy && op_go && op_sel == 2'b00) |=> !state_q.busy);

endmodule

// File: rtl/tfc_count_core.sv
module tfc_count_core
    import tfc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_cmd_t         cmd,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             at_max
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_q, count_d;

    always_comb begin
        count_d = count_q;
        if (cmd.clear)      count_d = '0;
        else if (cmd.load)  count_d = load_val;
        else if (cmd.step)  count_d = count_q + ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_d;
    end

    assign count  = count_q;
    assign at_max = &count_q;

    p_clear_zero_r5: assert property (@(posedge clk) disable iff (rst)
        cmd.clear |=> (count_q == '0));

    p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd.step && !cmd.clear && !cmd.load) |=> (count_q == $past(count_q) + ONE));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!cmd.step && !cmd.clear && !cmd.load) |=> $stable(count_q));

endmodule

// File: rtl/tfc_frame_counter.sv
module tfc_frame_counter
    import tfc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr_en,
    input  logic [CNT_W-1:0] reg_wr_data,
    input  logic             op_go,
    input  logic [1:0]       op_sel,
    input  logic             frame_stb,
    input  logic             rec_end,
    output logic [CNT_W-1:0] frame_cnt,
    output logic             op_busy,
    output logic             wr_done
);

    cnt_cmd_t  cmd;
    op_state_t state;
    logic      at_max;

    tfc_op_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .op_go     (op_go),
        .op_sel    (op_sel),
        .reg_wr_en (reg_wr_en),
        .frame_stb (frame_stb),
        .rec_end   (rec_end),
        .at_max    (at_max),
        .cmd       (cmd),
        .state     (state),
        .done      (wr_done)
    );

    tfc_count_core #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .load_val (reg_wr_data),
        .count    (frame_cnt),
        .at_max   (at_max)
    );

    assign op_busy = state.busy;

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (frame_cnt == '0 && !op_busy && !wr_done));

    p_done_at_zero_r4: assert property (@(posedge clk) disable iff (rst)
        wr_done |-> (frame_cnt == '0));

    p_busy_write_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (op_busy && reg_wr_en && !frame_stb) |=> $stable(frame_cnt));

    p_idle_load_r2: assert property (@(posedge clk) disable iff (rst)
        (!op_busy && reg_wr_en && !op_go) |=> (frame_cnt == $past(reg_wr_data)));

    p_rec_end_stops_r7: assert property (@(posedge clk) disable iff (rst)
        (op_busy && rec_end) |=> !op_busy);

endmodule

// File: tb/tfc_frame_counter_tb_top.sv
module tfc_frame_counter_tb_top;

    localparam int W = 16;
    localparam logic [W-1:0] MASK = '1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_wr_en = 1'b0;
    logic [W-1:0] reg_wr_data = '0;
    logic         op_go = 1'b0;
    logic [1:0]   op_sel = 2'b00;
    logic         frame_stb = 1'b0;
    logic         rec_end = 1'b0;
    logic [W-1:0] frame_cnt;
    logic         op_busy;
    logic         wr_done;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    tfc_frame_counter #(.CNT_W(W)) dut_i (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .op_go(op_go), .op_sel(op_sel), .frame_stb(frame_stb), .rec_end(rec_end),
        .frame_cnt(frame_cnt), .op_busy(op_busy), .wr_done(wr_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic load(input logic [W-1:0] v);
        reg_wr_en = 1'b1; reg_wr_data = v;
        step();
        reg_wr_en = 1'b0;
        check("R2 load", 32'(frame_cnt), 32'(v));
    endtask

    task automatic run_write(input int n, input bit gaps, input bit same_cycle);
        logic [W-1:0] v;
        v = W'(-n);
        if (same_cycle) begin
            reg_wr_en = 1'b1; reg_wr_data = v; op_go = 1'b1; op_sel = 2'b01;
            step();
            reg_wr_en = 1'b0; op_go = 1'b0;
            check("R10 load+write start", 32'(frame_cnt), 32'(v));
        end else begin
            load(v);
            op_go = 1'b1; op_sel = 2'b01;
            step();
            op_go = 1'b0;
            check("R3 write keeps load", 32'(frame_cnt), 32'(v));
        end
        check("R3 busy", 32'(op_busy), 1);
        for (int i = 1; i <= n; i++) begin
            frame_stb = 1'b1;
            step();
            frame_stb = 1'b0;
            check("R3 count", 32'(frame_cnt), 32'((v + W'(i)) & MASK));
            if (i < n) begin
                check("R4 busy before end", 32'(op_busy), 1);
                check("R4 no early done", 32'(wr_done), 0);
                if (gaps && (i % 3 == 0)) begin
                    step();
                    check("R3 no strobe no step", 32'(frame_cnt), 32'((v + W'(i)) & MASK));
                end
            end else begin
                check("R4 busy drops", 32'(op_busy), 0);
                check("R4 done rises", 32'(wr_done), 1);
            end
        end
        step();
        check("R4 done one cycle", 32'(wr_done), 0);
        frame_stb = 1'b1;
        step();
        frame_stb = 1'b0;
        check("R2 idle strobe ignored", 32'(frame_cnt), 0);
    endtask

    task automatic run_read(input logic [1:0] sel, input logic [W-1:0] pre, input int n,
                            input bit same_cycle, input bit busy_poke);
        if (same_cycle) begin
            reg_wr_en = 1'b1; reg_wr_data = pre; op_go = 1'b1; op_sel = sel;
            step();
            reg_wr_en = 1'b0; op_go = 1'b0;
            check("R10 clear beats load", 32'(frame_cnt), 0);
        end else begin
            load(pre);
            op_go = 1'b1; op_sel = sel;
            step();
            op_go = 1'b0;
            check("R5 start clears", 32'(frame_cnt), 0);
        end
        check("R5 busy", 32'(op_busy), 1);
        if (n == 0) begin
            rec_end = 1'b1;
            step();
            rec_end = 1'b0;
            check("R7 end no frames busy", 32'(op_busy), 0);
            check("R7 end no frames cnt", 32'(frame_cnt), 0);
        end
        for (int i = 1; i <= n; i++) begin
            frame_stb = 1'b1;
            if (i == n) rec_end = 1'b1;
            step();
            frame_stb = 1'b0; rec_end = 1'b0;
            if (i == n || (i & 32'hFFFF) == 0 || i < 4) begin
                check("R5 count", 32'(frame_cnt), 32'(i & 32'hFFFF));
                check("R6 no done", 32'(wr_done), 0);
                check("R7 busy", 32'(op_busy), (i < n) ? 1 : 0);
            end else if (wr_done !== 1'b0) begin
                check("R6 no done on wrap", 32'(wr_done), 0);
            end
            if (busy_poke && i == 1) begin
                reg_wr_en = 1'b1; reg_wr_data = 16'h1234; op_go = 1'b1; op_sel = 2'b01;
                step();
                reg_wr_en = 1'b0; op_go = 1'b0;
                check("R8 busy write ignored", 32'(frame_cnt), 1);
                check("R8 still busy", 32'(op_busy), 1);
            end
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        step(); step(); step();
        check("R1 reset count", 32'(frame_cnt), 0);
        check("R1 reset busy", 32'(op_busy), 0);
        check("R1 reset done", 32'(wr_done), 0);
        rst = 1'b0;
        step();

        // R2: idle load, idle strobes ignored
        load(16'hA5C3);
        frame_stb = 1'b1; step(); frame_stb = 1'b0;
        check("R2 idle strobe", 32'(frame_cnt), 32'h0000A5C3);

        // R9: class none starts nothing
        op_go = 1'b1; op_sel = 2'b00; step(); op_go = 1'b0;
        check("R9 no busy", 32'(op_busy), 0);
        check("R9 count kept", 32'(frame_cnt), 32'h0000A5C3);

        // R3/R4 sweep over write totals
        for (int n = 1; n <= 24; n++) run_write(n, n[0], 1'b0);
        run_write(1000, 1'b1, 1'b0);
        run_write(2, 1'b0, 1'b1);   // R10 write

        // R5/R7 reads and write-checks
        run_read(2'b10, 16'h7777, 0, 1'b0, 1'b0);
        for (int n = 1; n <= 12; n++) run_read(2'b10, 16'hFFFF, n, 1'b0, 1'b0);
        for (int n = 1; n <= 12; n++) run_read(2'b11, 16'h00F0, n, 1'b0, 1'b0);
        run_read(2'b10, 16'hBEEF, 5, 1'b1, 1'b0);  // R10 read
        run_read(2'b11, 16'h0001, 6, 1'b0, 1'b1);  // R8 while busy

        // R6: read wrapping past all ones
        run_read(2'b10, 16'h1111, 65537, 1'b0, 1'b0);

        // R1: reset in the middle of a write
        load(16'hFFF0);
        op_go = 1'b1; op_sel = 2'b01; step(); op_go = 1'b0;
        frame_stb = 1'b1; step(); frame_stb = 1'b0;
        rst = 1'b1; step(); rst = 1'b0;
        check("R1 mid-op reset count", 32'(frame_cnt), 0);
        check("R1 mid-op reset busy", 32'(op_busy), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule